// File: doc/BRIEF.md
# I3C Target Private-Header Acknowledge Controller

This block handles the address-header stage of an I3C target running in SDR mode. After the bus shows a Start or a Restart, the block collects the eight header bits: a 7-bit address and a read/write bit. It checks the address against the target's assigned dynamic address. It then decides whether to pull SDA low in the ninth bit slot, which is the acknowledge slot. Its inputs are already-sampled bus events: start/restart, stop, SCL rising-edge strobes carrying the SDA bit, and SCL falling-edge strobes. It also takes the transmit-FIFO "not empty" status and a few control settings.

Software can make the target refuse every private request with an auto-refuse control. It can arm a one-shot grant that accepts exactly one request while that refusal is active. Hardware disarms the one-shot grant when the grant is used. A private read is never accepted while the transmit FIFO is empty; that case also raises an underrun pulse. Status events leave the block as single-cycle pulses for an external interrupt register to latch. The direction of the last accepted request is kept as a level.

Top module: `tgt_priv_ack`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sda_pull_low`, `oneshot_pending`, `addr_hit_pulse`, `underrun_pulse` and `rnw_status` are all 0.
- R2: The block responds to headers only when `mode_sel` equals 2'b01 and `addr_assigned` is 1. Otherwise it produces no flag and never pulls SDA low.
- R3: Header bits arrive MSB first, one per `scl_rise` strobe. The first seven bits form the address and the eighth is R/W (0 = write, 1 = read). `addr_hit_pulse` is high in the cycle after the eighth strobe when the address equals `own_addr`, whether the answer is ACK or NACK.
- R4: A matching write is acknowledged when `auto_nack` is 0. It is refused when `auto_nack` is 1 and no one-shot grant is armed.
- R5: A matching read is acknowledged only when `tx_not_empty` is 1 and either `auto_nack` is 0 or a one-shot grant is armed. A matching read with `tx_not_empty` at 0 is refused, and `underrun_pulse` is raised in the same cycle as `addr_hit_pulse`.
- R6: A pulse on `oneshot_set` arms the grant, shown on `oneshot_pending`. Any acknowledged request clears the grant. A read refused because the FIFO is empty leaves the grant armed.
- R7: `rnw_status` takes the header's R/W bit only when a matching request is acknowledged. It keeps its value on any refusal, mismatch or broadcast header.
- R8: On an acknowledge, `sda_pull_low` goes high in the cycle after the first `scl_fall` strobe that follows the eighth bit. It goes low in the cycle after the next `scl_fall` strobe.
- R9: A `bus_stop` pulse at any point returns the block to idle. No flag follows it, and later bits are ignored until a new `bus_start`.
- R10: A non-matching address produces no flag and SDA stays released. The address 7'h7E never matches. After a mismatch, bits are ignored until the next `bus_start`, which restarts decoding with a fresh header.
- R11: `addr_hit_pulse` and `underrun_pulse` are high for exactly one cycle per header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Operating mode; 2'b01 enables SDR private handling |
| addr_assigned | input | 1 | A dynamic address has been assigned |
| own_addr | input | 7 | Assigned dynamic address |
| auto_nack | input | 1 | Refuse private requests unless a grant is armed |
| oneshot_set | input | 1 | Pulse arming the one-shot grant |
| tx_not_empty | input | 1 | Transmit FIFO holds data |
| bus_start | input | 1 | Start or Restart detected (pulse) |
| bus_stop | input | 1 | Stop detected (pulse) |
| scl_rise | input | 1 | SCL rising-edge strobe; SDA sampled with it |
| scl_fall | input | 1 | SCL falling-edge strobe |
| sda_in | input | 1 | Sampled SDA value for the current strobe |
| sda_pull_low | output | 1 | Drive SDA low (acknowledge) |
| oneshot_pending | output | 1 | One-shot grant armed |
| addr_hit_pulse | output | 1 | Dynamic address matched |
| underrun_pulse | output | 1 | Read requested with empty transmit FIFO |
| rnw_status | output | 1 | R/W bit of the last acknowledged request |

## Verification
The checker watches, on every cycle, how the outputs relate to one another and to the bus strobes:
- the acknowledge drive only starts on a falling-edge strobe and only ends after one;
- a stop always releases SDA;
- an underrun never appears without a hit;
- pulses never stretch beyond one cycle;
- a hit requires the SDR mode and an assigned address;
- the one-shot grant and the direction bit change only on an accepted request.

Which answer a given header gets is shown only by the bench's scenarios. That covers the bit order, the mix of refusal control, one-shot grant and FIFO status, the broadcast-then-restart sequence, and skipping bits after a mismatch or stop.

// File: rtl/tgt_hdr_pkg.sv
package tgt_hdr_pkg;

    localparam int ADDR_W = 7;
    localparam int HDR_W  = ADDR_W + 1;
    localparam logic [1:0] MODE_SDR = 2'b01;
    localparam logic [ADDR_W-1:0] BCAST_ADDR = 7'h7E;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WAIT_SLOT,
        ST_SLOT,
        ST_SKIP
    } hdr_state_e;

    typedef struct packed {
        logic hit;
        logic ack;
        logic underrun;
        logic consume;
        logic rnw;
    } verdict_t;

    // Decide the answer to a complete header.
    function automatic verdict_t judge(
        input logic              active,
        input logic [HDR_W-1:0]  hdr,
        input logic [ADDR_W-1:0] own,
        input logic              refuse,
        input logic              grant,
        input logic              tx_ne
    );
        verdict_t v;
        logic [ADDR_W-1:0] a;
        logic permit;
        a          = hdr[HDR_W-1:1];
        v.rnw      = hdr[0];
        v.hit      = active && (a == own) && (a != BCAST_ADDR);
        permit     = !refuse || grant;
        v.underrun = v.hit && v.rnw && !tx_ne;
        v.ack      = v.hit && permit && !v.underrun;
        v.consume  = v.ack && grant;
        return v;
    endfunction

endpackage

// File: rtl/tgt_hdr_shift.sv
module tgt_hdr_shift
    import tgt_hdr_pkg::*;
#(
    parameter int W = HDR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         enable,
    input  logic         strobe,
    input  logic         bit_in,
    output logic [W-1:0] word_next,
    output logic         last
);
    localparam int CW = $clog2(W + 1);

    logic [W-2:0]  sh;
    logic [CW-1:0] cnt;

    assign word_next = {sh, bit_in};
    assign last      = enable && strobe && (cnt == CW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh  <= '0;
            cnt <= '0;
        end else if (enable && strobe) begin
            sh  <= word_next[W-2:0];
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/tgt_ack_judge.sv
module tgt_ack_judge
    import tgt_hdr_pkg::*;
(
    input  logic              active,
    input  logic [HDR_W-1:0]  hdr,
    input  logic [ADDR_W-1:0] own,
    input  logic              refuse,
    input  logic              grant,
    input  logic              tx_ne,
    output verdict_t          verdict
);
    always_comb verdict = judge(active, hdr, own, refuse, grant, tx_ne);
endmodule

// File: rtl/tgt_oneshot.sv
module tgt_oneshot (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic consume,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst)          pending <= 1'b0;
        else if (set)     pending <= 1'b1;
        else if (consume) pending <= 1'b0;
    end
endmodule

// File: rtl/tgt_priv_ack.sv
module tgt_priv_ack
    import tgt_hdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              addr_assigned,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              auto_nack,
    input  logic              oneshot_set,
    input  logic              tx_not_empty,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    output logic              sda_pull_low,
    output logic              oneshot_pending,
    output logic              addr_hit_pulse,
    output logic              underrun_pulse,
    output logic              rnw_status
);
    hdr_state_e        st, st_n;
    logic              active;
    logic [HDR_W-1:0]  hdr_word;
    logic              hdr_last;
    logic              fire;
    verdict_t          v;

    assign active = (mode_sel == MODE_SDR) && addr_assigned;
    assign fire   = hdr_last && !bus_stop && !bus_start;

    tgt_hdr_shift #(.W(HDR_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .clear     (bus_start || bus_stop),
        .enable    (st == ST_HDR),
        .strobe    (scl_rise),
        .bit_in    (sda_in),
        .word_next (hdr_word),
        .last      (hdr_last)
    );

    tgt_ack_judge u_judge (
        .active  (active),
        .hdr     (hdr_word),
        .own     (own_addr),
        .refuse  (auto_nack),
        .grant   (oneshot_pending),
        .tx_ne   (tx_not_empty),
        .verdict (v)
    );

    tgt_oneshot u_grant (
        .clk     (clk),
        .rst     (rst),
        .set     (oneshot_set),
        .consume (fire && v.consume),
        .pending (oneshot_pending)
    );

    always_comb begin
        st_n = st;
        if (bus_stop) begin
            st_n = ST_IDLE;
        end else if (bus_start) begin
            st_n = ST_HDR;
        end else begin
            case (st)
                ST_HDR:       if (hdr_last) st_n = v.ack ? ST_WAIT_SLOT : ST_SKIP;
                ST_WAIT_SLOT: if (scl_fall) st_n = ST_SLOT;
                ST_SLOT:      if (scl_fall) st_n = ST_SKIP;
                default:      st_n = st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st             <= ST_IDLE;
            addr_hit_pulse <= 1'b0;
            underrun_pulse <= 1'b0;
            rnw_status     <= 1'b0;
        end else begin
            st             <= st_n;
            addr_hit_pulse <= fire && v.hit;
            underrun_pulse <= fire && v.underrun;
            if (fire && v.ack) rnw_status <= v.rnw;
        end
    end

    assign sda_pull_low = (st == ST_SLOT);
endmodule

// File: rtl/tgt_priv_ack_chk.sv
module tgt_priv_ack_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic       addr_assigned,
    input logic       bus_start,
    input logic       bus_stop,
    input logic       scl_fall,
    input logic       sda_pull_low,
    input logic       oneshot_pending,
    input logic       addr_hit_pulse,
    input logic       underrun_pulse,
    input logic       rnw_status
);
    assert_pull_begins_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_low) |-> $past(scl_fall));

    assert_pull_ends_on_event_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_pull_low) |-> ($past(scl_fall) || $past(bus_stop) || $past(bus_start)));

    assert_stop_quiets_R9: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> (!sda_pull_low && !addr_hit_pulse && !underrun_pulse));

    assert_underrun_needs_hit_R5: assert property (@(posedge clk) disable iff (rst)
        underrun_pulse |-> addr_hit_pulse);

    assert_hit_single_cycle_R11: assert property (@(posedge clk) disable iff (rst)
        addr_hit_pulse |=> !addr_hit_pulse);

    assert_hit_needs_sdr_R2: assert property (@(posedge clk) disable iff (rst)
        addr_hit_pulse |-> $past(mode_sel == 2'b01 && addr_assigned));

    assert_grant_used_on_ack_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(oneshot_pending) |-> (addr_hit_pulse && !underrun_pulse));

    assert_rnw_moves_on_ack_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(rnw_status) |-> (addr_hit_pulse && !underrun_pulse));
endmodule

bind tgt_priv_ack tgt_priv_ack_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .mode_sel        (mode_sel),
    .addr_assigned   (addr_assigned),
    .bus_start       (bus_start),
    .bus_stop        (bus_stop),
    .scl_fall        (scl_fall),
    .sda_pull_low    (sda_pull_low),
    .oneshot_pending (oneshot_pending),
    .addr_hit_pulse  (addr_hit_pulse),
    .underrun_pulse  (underrun_pulse),
    .rnw_status      (rnw_status)
);

// File: tb/sim_tgt_priv_ack.sv
module sim_tgt_priv_ack;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b01;
    logic       addr_assigned = 1'b1;
    logic [6:0] own_addr = 7'h13;
    logic       auto_nack = 1'b0;
    logic       oneshot_set = 1'b0;
    logic       tx_not_empty = 1'b0;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       scl_rise = 1'b0;
    logic       scl_fall = 1'b0;
    logic       sda_in = 1'b0;
    logic       sda_pull_low, oneshot_pending, addr_hit_pulse, underrun_pulse, rnw_status;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tgt_priv_ack u0 (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge clk); sda_in = b[i]; scl_rise = 1'b1;
            @(negedge clk); scl_rise = 1'b0;
        end
    endtask

    // Ninth slot: returns pull before the fall, during the slot and after it.
    task automatic ack_slot(output logic pre, output logic mid, output logic post);
        pre = sda_pull_low;
        scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0; mid = sda_pull_low; scl_rise = 1'b1;
        @(negedge clk) scl_rise = 1'b0; scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0; post = sda_pull_low;
    endtask

    task automatic header(input logic [6:0] a, input logic rw, input bit do_start,
                          output logic hit, output logic und, output logic ackd);
        logic hit2, pre, post;
        if (do_start) pulse_start();
        send_bits({a, rw}, 8);
        hit = addr_hit_pulse; und = underrun_pulse;
        @(negedge clk) hit2 = addr_hit_pulse;
        chk("R11", "hit pulse length", hit2, 0);
        ack_slot(pre, ackd, post);
        chk("R8", "pull before slot", pre, 0);
        chk("R8", "pull after slot", post, 0);
    endtask

    task automatic t_reset();
        chk("R1", "pull", sda_pull_low, 0);
        chk("R1", "grant", oneshot_pending, 0);
        chk("R1", "hit", addr_hit_pulse, 0);
        chk("R1", "underrun", underrun_pulse, 0);
        chk("R1", "rnw", rnw_status, 0);
    endtask

    task automatic t_write_basic();
        logic h, u, a;
        header(7'h13, 1'b0, 1, h, u, a);
        chk("R3", "write hit", h, 1);
        chk("R4", "write ack", a, 1);
        chk("R7", "rnw after write", rnw_status, 0);
        header(7'h64, 1'b0, 1, h, u, a);
        chk("R3", "reversed address hit", h, 0);
    endtask

    task automatic t_read_paths();
        logic h, u, a;
        tx_not_empty = 1'b1;
        header(7'h13, 1'b1, 1, h, u, a);
        chk("R5", "read with data ack", a, 1);
        chk("R7", "rnw after read", rnw_status, 1);
        header(7'h13, 1'b0, 1, h, u, a);
        tx_not_empty = 1'b0;
        header(7'h13, 1'b1, 1, h, u, a);
        chk("R5", "empty read hit", h, 1);
        chk("R5", "empty read underrun", u, 1);
        chk("R5", "empty read ack", a, 0);
        chk("R7", "rnw held on refusal", rnw_status, 0);
    endtask

    task automatic t_auto_nack();
        logic h, u, a;
        auto_nack = 1'b1; tx_not_empty = 1'b1;
        header(7'h13, 1'b0, 1, h, u, a);
        chk("R4", "refused write hit", h, 1);
        chk("R4", "refused write ack", a, 0);
        header(7'h13, 1'b1, 1, h, u, a);
        chk("R5", "refused read ack", a, 0);
        chk("R5", "refused read underrun", u, 0);
        chk("R7", "rnw held", rnw_status, 0);
    endtask

    task automatic t_oneshot();
        logic h, u, a;
        auto_nack = 1'b1; tx_not_empty = 1'b0;
        @(negedge clk) oneshot_set = 1'b1;
        @(negedge clk) oneshot_set = 1'b0;
        chk("R6", "grant armed", oneshot_pending, 1);
        header(7'h13, 1'b1, 1, h, u, a);
        chk("R6", "empty read ack under grant", a, 0);
        chk("R6", "empty read underrun under grant", u, 1);
        chk("R6", "grant kept", oneshot_pending, 1);
        header(7'h13, 1'b1, 1, h, u, a);
        tx_not_empty = 1'b1;
        header(7'h13, 1'b1, 1, h, u, a);
        chk("R6", "granted read ack", a, 1);
        chk("R6", "grant used", oneshot_pending, 0);
        chk("R7", "rnw after granted read", rnw_status, 1);
        header(7'h13, 1'b0, 1, h, u, a);
        chk("R6", "second write refused", a, 0);
        auto_nack = 1'b0;
    endtask

    task automatic t_mismatch();
        logic h, u, a;
        header(7'h12, 1'b0, 1, h, u, a);
        chk("R10", "mismatch hit", h, 0);
        chk("R10", "mismatch ack", a, 0);
        header(7'h13, 1'b0, 0, h, u, a);
        chk("R10", "bits after mismatch hit", h, 0);
        chk("R10", "bits after mismatch ack", a, 0);
    endtask

    task automatic t_broadcast_restart();
        logic h, u, a;
        header(7'h7E, 1'b0, 1, h, u, a);
        chk("R10", "broadcast hit", h, 0);
        header(7'h13, 1'b0, 1, h, u, a);
        chk("R10", "after restart hit", h, 1);
        chk("R10", "after restart ack", a, 1);
    endtask

    task automatic t_stop();
        logic h;
        pulse_start();
        send_bits({7'h13, 1'b0}, 4);
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
        send_bits({7'h13, 1'b0}, 8);
        h = addr_hit_pulse;
        chk("R9", "hit after stop", h, 0);
        @(negedge clk) scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0;
        chk("R9", "pull after stop", sda_pull_low, 0);
    endtask

    task automatic t_disabled();
        logic h, u, a;
        mode_sel = 2'b10;
        header(7'h13, 1'b0, 1, h, u, a);
        chk("R2", "wrong mode hit", h, 0);
        chk("R2", "wrong mode ack", a, 0);
        mode_sel = 2'b01; addr_assigned = 1'b0;
        header(7'h13, 1'b0, 1, h, u, a);
        chk("R2", "unassigned hit", h, 0);
        chk("R2", "unassigned ack", a, 0);
        addr_assigned = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_basic();
        t_read_paths();
        t_auto_nack();
        t_oneshot();
        t_mismatch();
        t_broadcast_restart();
        t_stop();
        t_disabled();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule